// File: doc/BRIEF.md
# Two-Level Page Table Walker

This block turns a 32-bit virtual address into a physical address. It reads one or two descriptors from a translation table held in memory. A base register, written through a small write port, says where the first-level table sits. The walker fetches the first-level descriptor selected by the top twelve address bits. That descriptor either:

- faults,
- maps a whole 1 MB section directly, or
- points to a second-level table.

A second-level table splits the 1 MB region into 4 KB pages, and the walker then fetches one more descriptor to finish the walk.

A client offers one address at a time on a valid/ready request port and gets back a one-cycle response. The response carries the physical address, a fault flag, the level at which the walk ended and the raw bits of the last descriptor read. The walker does not interpret those attribute bits. Descriptor reads go out on a single-beat read port, and the memory answers with a valid pulse some cycles later.

Top module: `ptw_top`

## Requirements
- R1: While reset is high and in the first cycle after it, `req_ready` is 1, `rsp_valid` is 0 and `mem_req_valid` is 0. The base register resets to zero.
- R2: The first descriptor is read from `{base[31:14], va[31:20], 2'b00}`. Base bits 13:0 are ignored.
- R3: A first-level descriptor whose bits 1:0 equal 00 ends the walk. The response has `rsp_fault`=1, `rsp_level`=1 and `rsp_pa`=0, and no second read is made.
- R4: A first-level descriptor with bit 1 set is a section. The response has `rsp_fault`=0, `rsp_level`=1 and `rsp_pa` = `{desc[31:20], va[19:0]}`. Bits 18 and 0 of the descriptor do not change the result.
- R5: A first-level descriptor whose bits 1:0 equal 01 causes exactly one more read, from `{desc[31:10], va[19:12], 2'b00}`.
- R6: A second-level descriptor whose bits 1:0 equal 00 or 01 gives `rsp_fault`=1, `rsp_level`=2 and `rsp_pa`=0.
- R7: A second-level descriptor with bit 1 set is a small page. The response has `rsp_fault`=0, `rsp_level`=2 and `rsp_pa` = `{desc[31:12], va[11:0]}`.
- R8: `req_ready` is low from the cycle after a request is accepted until the response. `rsp_valid` is high for exactly one cycle per request. `mem_req_valid` is high for exactly one cycle per descriptor read.
- R9: `rsp_attr` equals the last descriptor read, unchanged.
- R10: A base write made while the walker is idle applies to the next request.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| base_we | input | 1 | Base register write strobe |
| base_wdata | input | 32 | New first-level table address |
| req_valid | input | 1 | Translation request offered |
| req_ready | output | 1 | Walker idle and able to accept |
| req_va | input | 32 | Virtual address to translate |
| rsp_valid | output | 1 | One-cycle response strobe |
| rsp_pa | output | 32 | Physical address (zero on fault) |
| rsp_fault | output | 1 | Translation fault |
| rsp_level | output | 2 | Level that ended the walk (1 or 2) |
| rsp_attr | output | 32 | Raw bits of the last descriptor read |
| mem_req_valid | output | 1 | Descriptor read request |
| mem_req_addr | output | 32 | Descriptor byte address |
| mem_rsp_valid | input | 1 | Read data strobe |
| mem_rsp_data | input | 32 | Descriptor read data |

## Verification
The stimulus comes from random virtual addresses drawn over a table filled with a random mix of the three first-level and three second-level encodings. Directed addresses are added at the lowest and highest first-level index, a section carrying a known attribute pattern, and a second-level entry using the unsupported large-page code. Checking the fetch addresses as well as the number of reads separates the section path from the table path. It also catches any extra read after a first-level fault. Rewriting the base with nonzero low bits, and then pointing it at a second table with different content, shows which bits of the base are used and when a new base takes effect.

// File: rtl/walk_pkg.sv
package walk_pkg;
  typedef enum logic [2:0] {
    ST_IDLE, ST_L1_FETCH, ST_L1_WAIT, ST_L2_FETCH, ST_L2_WAIT, ST_DONE
  } walk_state_e;

  typedef enum logic [1:0] {
    DK_FAULT, DK_BLOCK, DK_NEXT
  } desc_kind_e;
endpackage

// File: rtl/walk_desc_decode.sv
module walk_desc_decode
  import walk_pkg::*;
#(
  parameter int AW       = 32,
  parameter int L2_IDX_W = 8,
  parameter int PAGE_W   = 12,
  parameter bit SECOND   = 1'b0
) (
  input  logic [AW-1:0] desc,
  input  logic [AW-1:0] va,
  output desc_kind_e    kind,
  output logic [AW-1:0] addr
);
  localparam int SECT_W = L2_IDX_W + PAGE_W;

  generate
    if (!SECOND) begin : g_first
      // bit1 set: section; 01: pointer to next table; 00: fault
      always_comb begin
        kind = DK_FAULT;
        addr = '0;
        if (desc[1]) begin
          kind = DK_BLOCK;
          addr = {desc[AW-1:SECT_W], va[SECT_W-1:0]};
        end else if (desc[0]) begin
          kind = DK_NEXT;
          addr = {desc[AW-1:L2_IDX_W+2], va[SECT_W-1:PAGE_W], 2'b00};
        end
      end
      logic unused_first;
      assign unused_first = ^{va[AW-1:SECT_W]};
    end else begin : g_second
      // bit1 set: small page; 00 and 01 (large page) both fault
      always_comb begin
        kind = DK_FAULT;
        addr = '0;
        if (desc[1]) begin
          kind = DK_BLOCK;
          addr = {desc[AW-1:PAGE_W], va[PAGE_W-1:0]};
        end
      end
      logic unused_second;
      assign unused_second = ^{desc[PAGE_W-1:2], desc[0], va[AW-1:PAGE_W]};
    end
  endgenerate
endmodule

// File: rtl/ptw_top.sv
module ptw_top
  import walk_pkg::*;
#(
  parameter int AW       = 32,
  parameter int L1_IDX_W = 12,
  parameter int L2_IDX_W = 8,
  parameter int PAGE_W   = 12
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          base_we,
  input  logic [31:0]   base_wdata,
  input  logic          req_valid,
  output logic          req_ready,
  input  logic [31:0]   req_va,
  output logic          rsp_valid,
  output logic [31:0]   rsp_pa,
  output logic          rsp_fault,
  output logic [1:0]    rsp_level,
  output logic [31:0]   rsp_attr,
  output logic          mem_req_valid,
  output logic [31:0]   mem_req_addr,
  input  logic          mem_rsp_valid,
  input  logic [31:0]   mem_rsp_data
);
  localparam int SECT_W    = L2_IDX_W + PAGE_W;
  localparam int TBL_ALIGN = L1_IDX_W + 2;

  walk_state_e             state;
  logic [AW-1:0]           va_q;
  logic [AW-1:TBL_ALIGN]   base_q;
  logic [AW-1:0]           addr_q;
  logic [AW-1:0]           pa_q;
  logic [AW-1:0]           attr_q;
  logic                    fault_q;
  logic [1:0]              level_q;

  desc_kind_e    l1_kind, l2_kind;
  logic [AW-1:0] l1_addr, l2_addr;

  walk_desc_decode #(.AW(AW), .L2_IDX_W(L2_IDX_W), .PAGE_W(PAGE_W), .SECOND(1'b0)) u_dec_l1 (
    .desc(mem_rsp_data), .va(va_q), .kind(l1_kind), .addr(l1_addr)
  );

  walk_desc_decode #(.AW(AW), .L2_IDX_W(L2_IDX_W), .PAGE_W(PAGE_W), .SECOND(1'b1)) u_dec_l2 (
    .desc(mem_rsp_data), .va(va_q), .kind(l2_kind), .addr(l2_addr)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      state   <= ST_IDLE;
      base_q  <= '0;
      va_q    <= '0;
      addr_q  <= '0;
      pa_q    <= '0;
      attr_q  <= '0;
      fault_q <= 1'b0;
      level_q <= 2'd0;
    end else begin
      if (base_we) base_q <= base_wdata[AW-1:TBL_ALIGN];
      case (state)
        ST_IDLE: if (req_valid) begin
          va_q   <= req_va;
          addr_q <= {base_q, req_va[AW-1:SECT_W], 2'b00};
          state  <= ST_L1_FETCH;
        end
        ST_L1_FETCH: state <= ST_L1_WAIT;
        ST_L1_WAIT: if (mem_rsp_valid) begin
          attr_q  <= mem_rsp_data;
          level_q <= 2'd1;
          case (l1_kind)
            DK_BLOCK: begin
              fault_q <= 1'b0;
              pa_q    <= l1_addr;
              state   <= ST_DONE;
            end
            DK_NEXT: begin
              addr_q <= l1_addr;
              state  <= ST_L2_FETCH;
            end
            default: begin
              fault_q <= 1'b1;
              pa_q    <= '0;
              state   <= ST_DONE;
            end
          endcase
        end
        ST_L2_FETCH: state <= ST_L2_WAIT;
        ST_L2_WAIT: if (mem_rsp_valid) begin
          attr_q  <= mem_rsp_data;
          level_q <= 2'd2;
          state   <= ST_DONE;
          if (l2_kind == DK_BLOCK) begin
            fault_q <= 1'b0;
            pa_q    <= l2_addr;
          end else begin
            fault_q <= 1'b1;
            pa_q    <= '0;
          end
        end
        ST_DONE: state <= ST_IDLE;
        default: state <= ST_IDLE;
      endcase
    end
  end

  assign req_ready     = (state == ST_IDLE);
  assign mem_req_valid = (state == ST_L1_FETCH) || (state == ST_L2_FETCH);
  assign mem_req_addr  = addr_q;
  assign rsp_valid     = (state == ST_DONE);
  assign rsp_pa        = pa_q;
  assign rsp_fault     = fault_q;
  assign rsp_level     = level_q;
  assign rsp_attr      = attr_q;

  logic unused_top;
  assign unused_top = ^{base_wdata[TBL_ALIGN-1:0]};
endmodule

// File: rtl/ptw_checker.sv
module ptw_checker #(
  parameter int AW     = 32,
  parameter int PAGE_W = 12,
  parameter int SECT_W = 20
) (
  input logic          clk,
  input logic          rst,
  input logic          req_valid,
  input logic          req_ready,
  input logic          mem_req_valid,
  input logic          rsp_valid,
  input logic          rsp_fault,
  input logic [1:0]    rsp_level,
  input logic [AW-1:0] rsp_pa,
  input logic [AW-1:0] rsp_attr
);
  AST_RESET_IDLE: assert property (@(posedge clk) rst |=> (req_ready && !rsp_valid && !mem_req_valid)); // R1
  AST_FAULT_PA_ZERO: assert property (@(posedge clk) disable iff (rst)
    (rsp_valid && rsp_fault) |-> (rsp_pa == '0)); // R3
  AST_SECTION_PA: assert property (@(posedge clk) disable iff (rst)
    (rsp_valid && !rsp_fault && rsp_level == 2'd1) |-> (rsp_pa[AW-1:SECT_W] == rsp_attr[AW-1:SECT_W])); // R4
  AST_PAGE_PA: assert property (@(posedge clk) disable iff (rst)
    (rsp_valid && !rsp_fault && rsp_level == 2'd2) |-> (rsp_pa[AW-1:PAGE_W] == rsp_attr[AW-1:PAGE_W])); // R7
  AST_LEVEL_RANGE: assert property (@(posedge clk) disable iff (rst)
    rsp_valid |-> (rsp_level == 2'd1 || rsp_level == 2'd2)); // R6
  AST_BUSY_AFTER_ACCEPT: assert property (@(posedge clk) disable iff (rst)
    (req_valid && req_ready) |=> !req_ready); // R8
  AST_RSP_PULSE: assert property (@(posedge clk) disable iff (rst)
    rsp_valid |=> (!rsp_valid && req_ready)); // R8
  AST_FETCH_PULSE: assert property (@(posedge clk) disable iff (rst)
    mem_req_valid |=> !mem_req_valid); // R8
  AST_NO_FETCH_IN_RSP: assert property (@(posedge clk) disable iff (rst)
    rsp_valid |-> !mem_req_valid); // R8
endmodule

bind ptw_top ptw_checker #(.AW(AW), .PAGE_W(PAGE_W), .SECT_W(L2_IDX_W + PAGE_W)) u_chk (
  .clk(clk), .rst(rst), .req_valid(req_valid), .req_ready(req_ready),
  .mem_req_valid(mem_req_valid), .rsp_valid(rsp_valid), .rsp_fault(rsp_fault),
  .rsp_level(rsp_level), .rsp_pa(rsp_pa), .rsp_attr(rsp_attr)
);

// File: tb/ptw_top_tb.sv
module ptw_top_tb;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        base_we = 1'b0;
  logic [31:0] base_wdata = '0;
  logic        req_valid = 1'b0;
  logic        req_ready;
  logic [31:0] req_va = '0;
  logic        rsp_valid;
  logic [31:0] rsp_pa;
  logic        rsp_fault;
  logic [1:0]  rsp_level;
  logic [31:0] rsp_attr;
  logic        mem_req_valid;
  logic [31:0] mem_req_addr;
  logic        mem_rsp_valid = 1'b0;
  logic [31:0] mem_rsp_data = '0;

  int checks = 0;
  int failures = 0;
  logic [31:0] cur_base = '0;
  logic [31:0] mem [int unsigned];
  int          fetch_cnt;
  logic [31:0] fetch_addr [2];

  always #2 clk = ~clk;

  ptw_top u_dut (
    .clk(clk), .rst(rst), .base_we(base_we), .base_wdata(base_wdata),
    .req_valid(req_valid), .req_ready(req_ready), .req_va(req_va),
    .rsp_valid(rsp_valid), .rsp_pa(rsp_pa), .rsp_fault(rsp_fault),
    .rsp_level(rsp_level), .rsp_attr(rsp_attr),
    .mem_req_valid(mem_req_valid), .mem_req_addr(mem_req_addr),
    .mem_rsp_valid(mem_rsp_valid), .mem_rsp_data(mem_rsp_data)
  );

  function automatic logic [31:0] rd(input logic [31:0] a);
    return mem.exists(a) ? mem[a] : 32'h0;
  endfunction

  task automatic chk(input bit ok, input string tag, input string what,
                     input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s %s actual=%h expected=%h", tag, what, act, exp);
    end
  endtask

  // memory model: latency 1..3 cycles, one beat per request
  initial begin
    forever begin
      @(negedge clk);
      mem_rsp_valid = 1'b0;
      if (mem_req_valid) begin
        logic [31:0] a;
        a = mem_req_addr;
        if (fetch_cnt < 2) fetch_addr[fetch_cnt] = a;
        fetch_cnt++;
        repeat (1 + ($urandom % 3)) @(negedge clk);
        mem_rsp_data  = rd(a);
        mem_rsp_valid = 1'b1;
      end
    end
  end

  function automatic void ref_walk(input logic [31:0] base, input logic [31:0] va,
      output logic [31:0] pa, output logic [31:0] attr, output logic [31:0] a1,
      output logic [31:0] a2, output bit flt, output int lvl, output int nf);
    logic [31:0] d1, d2;
    a1 = {base[31:14], va[31:20], 2'b00};
    d1 = rd(a1);
    a2 = '0;
    nf = 1;
    lvl = 1;
    attr = d1;
    if (d1[1]) begin flt = 1'b0; pa = {d1[31:20], va[19:0]}; end
    else if (!d1[0]) begin flt = 1'b1; pa = '0; end
    else begin
      a2 = {d1[31:10], va[19:12], 2'b00};
      nf = 2;
      lvl = 2;
      d2 = rd(a2);
      attr = d2;
      if (d2[1]) begin flt = 1'b0; pa = {d2[31:12], va[11:0]}; end
      else begin flt = 1'b1; pa = '0; end
    end
  endfunction

  task automatic write_base(input logic [31:0] v);
    @(negedge clk);
    base_we = 1'b1;
    base_wdata = v;
    @(negedge clk);
    base_we = 1'b0;
    cur_base = v;
  endtask

  task automatic walk(input logic [31:0] va);
    logic [31:0] pa, attr, a1, a2;
    bit flt;
    int lvl, nf;
    string tag;
    ref_walk(cur_base, va, pa, attr, a1, a2, flt, lvl, nf);
    if (flt && lvl == 1) tag = "R3";
    else if (lvl == 1) tag = "R4";
    else if (flt) tag = "R6";
    else tag = "R7";
    @(negedge clk);
    while (!req_ready) @(negedge clk);
    fetch_cnt = 0;
    req_valid = 1'b1;
    req_va = va;
    @(negedge clk);
    req_valid = 1'b0;
    chk(!req_ready, "R8", "ready during walk", {31'b0, req_ready}, 32'h0);
    while (!rsp_valid) @(negedge clk);
    chk(rsp_pa == pa, tag, "pa", rsp_pa, pa);
    chk(rsp_fault == flt && rsp_level == lvl[1:0], tag, "fault/level",
        {rsp_fault, 29'b0, rsp_level}, {flt, 29'b0, lvl[1:0]});
    chk(rsp_attr == attr, "R9", "attr", rsp_attr, attr);
    chk(fetch_cnt == nf, (nf == 1) ? "R3" : "R5", "fetch count", fetch_cnt, nf);
    chk(fetch_addr[0] == a1, "R2", "L1 addr", fetch_addr[0], a1);
    if (nf == 2) chk(fetch_addr[1] == a2, "R5", "L2 addr", fetch_addr[1], a2);
    @(negedge clk);
    chk(!rsp_valid && req_ready, "R8", "rsp pulse/ready",
        {30'b0, rsp_valid, req_ready}, 32'h1);
  endtask

  // fill L1 indices [0,63] and [4032,4095] with random descriptors
  task automatic fill(input logic [31:0] base, input logic [31:0] l2_region);
    for (int i = 0; i < 4096; i++) begin
      if (i < 64 || i >= 4032) begin
        logic [31:0] a, r;
        a = {base[31:14], i[11:0], 2'b00};
        r = $urandom;
        case ($urandom % 3)
          0: mem[a] = {r[31:2], 2'b00};
          1: mem[a] = {r[31:2], 1'b1, r[0]};
          default: begin
            logic [31:0] tb;
            tb = l2_region + (i << 10);
            mem[a] = {tb[31:10], r[9:2], 2'b01};
            for (int j = 0; j < 256; j++) begin
              logic [31:0] e;
              e = $urandom;
              mem[tb + (j << 2)] = e;
            end
          end
        endcase
      end
    end
  endtask

  function automatic logic [31:0] rand_va();
    logic [31:0] r;
    int idx;
    r = $urandom;
    idx = ($urandom % 2) ? ($urandom % 64) : (4032 + $urandom % 64);
    return {idx[11:0], r[19:0]};
  endfunction

  initial begin
    void'($urandom(32'd1234));
    fetch_cnt = 0;
    repeat (3) @(negedge clk);
    // R1: state held in reset
    chk(req_ready && !rsp_valid && !mem_req_valid, "R1", "reset outputs",
        {29'b0, req_ready, rsp_valid, mem_req_valid}, 32'h4);
    @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    chk(req_ready && !rsp_valid && !mem_req_valid, "R1", "after reset",
        {29'b0, req_ready, rsp_valid, mem_req_valid}, 32'h4);

    fill(32'h0008_0000, 32'h0100_0000);
    fill(32'h000C_0000, 32'h0200_0000);
    // directed descriptors in table A
    mem[32'h0008_0000] = 32'hABC0_0000 | 32'h15DE6;       // section, attr pattern
    mem[32'h0008_0004] = 32'h0000_0000;                   // L1 fault
    mem[32'h0008_0008] = 32'h0300_0001;                   // pointer
    mem[32'h0300_0000] = 32'h1234_5002;                   // small page
    mem[32'h0300_0004] = 32'h0000_0000;                   // L2 fault
    mem[32'h0300_0008] = 32'h5678_9001;                   // large page -> fault
    mem[32'h0008_3FFC] = 32'hFFF4_0003;                   // section, bit18/bit0 set
    mem[32'h000C_0000] = 32'h5550_0002;                   // table B index 0

    // R2: low base bits ignored
    write_base(32'h0008_3ABC);
    walk(32'h0001_2345);  // R4
    walk(32'h0011_1111);  // R3
    walk(32'h0020_0ABC);  // R7
    walk(32'h0020_1FFF);  // R6
    walk(32'h0020_2000);  // R6 large page
    walk(32'hFFFF_FFFF);  // R4 top index
    chk(rsp_pa == 32'hFFFF_FFFF, "R4", "top section pa", rsp_pa, 32'hFFFF_FFFF);

    for (int n = 0; n < 300; n++) walk(rand_va());

    // R10: new base applies to the next walk
    write_base(32'h000C_0000);
    walk(32'h000A_BCDE);
    chk(rsp_pa == 32'h555A_BCDE, "R10", "walk after base change", rsp_pa, 32'h555A_BCDE);
    for (int n = 0; n < 100; n++) walk(rand_va());

    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    failures++;
    checks++;
    $display("FAIL watchdog expired actual=running expected=done");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule